// File: doc/BRIEF.md
# Debug Run-Control Register Unit

This block holds the debug control and status registers that let an external debugger halt, resume and reset a single core. A debugger reaches it through a 32-bit register request port: each request names an address, a direction and (for writes) a data word, and the block answers one cycle later with SUCCESS or FAILED and, for reads, a data word. Writes to the control register turn into requests toward the core. The core halt and reset requests are levels. The resume request is started by a write and then held until the core acknowledges it. Reads of the status register return a picture of the core's live halted, running and have-reset signals.

The run-control behaviour is a three-state machine. `RC_OFF` is the inactive state: every core request is low and a control write can only change the activation bit. The transition `ACTIVATE` (a control write with bit 0 set) leads to `RC_ON`. From `RC_ON`, the transition `START_RESUME` (a control write with bit 0 and bit 30 set and bit 31 clear) leads to `RC_RESUME`, where the resume request is driven. `ACK` (the core's resume acknowledge) takes `RC_RESUME` back to `RC_ON`. `DEACTIVATE` (a control write with bit 0 clear) takes either active state to `RC_OFF` and has priority over `ACK`. Abstract commands and the data registers belong to a different block.

Top module: `dbg_runctl`

## Requirements
- R1: After reset `rsp_valid`, `core_halt_req`, `core_resume_req` and `core_ndm_reset` are 0 and the unit is inactive. A control read then returns 0.
- R2: A request with `req_valid`=1 produces exactly one response with `rsp_valid`=1 in the next cycle. In a cycle with no request, `rsp_valid` is 0 in the next cycle.
- R3: The owned addresses are 0x10 (control), 0x11 (status) and 0x12 (hart information). A request to any other address gets `rsp_ok`=0 (FAILED) and `rsp_rdata`=0, and it changes no state. A request to an owned address gets `rsp_ok`=1 (SUCCESS). `req_write`=1 selects a write.
- R4: While the unit is inactive, a control write changes only the activation bit (bit 0). Bits 31, 30 and 1 are ignored, and all three core requests stay 0.
- R5: While the unit is active, a control write with bit 0 set drives `core_halt_req` from bit 31 and `core_ndm_reset` from bit 1. Both take their new values in the cycle after the write.
- R6: A control write with bit 0 clear deactivates the unit. In the next cycle all three core requests are 0, even if a resume acknowledge arrives in the same cycle.
- R7: An active control write with bit 30 set and bit 31 clear raises `core_resume_req` in the next cycle. The request stays high until `core_resume_ack` is seen and drops in the cycle after that. If the same write has bit 31 set, the resume is ignored.
- R8: A control read returns the halt request in bit 31, the reset request in bit 1 and the activation bit in bit 0. Every other bit, bit 30 included, reads 0.
- R9: A status read returns `core_running` in bits 11 and 10, `core_halted` in bits 9 and 8, `core_have_reset` in bits 19 and 18, and the version 2 in bits 3:0. All other bits read 0. The core inputs are sampled in the request cycle.
- R10: The hart information register reads 0. Writes to the status or hart information register return SUCCESS and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ok | output | 1 | 1 = SUCCESS, 0 = FAILED |
| rsp_rdata | output | 32 | Read data |
| core_halt_req | output | 1 | Halt request level to the core |
| core_resume_req | output | 1 | Resume request, held until acknowledged |
| core_ndm_reset | output | 1 | Reset request level to the core |
| core_resume_ack | input | 1 | Core has resumed |
| core_halted | input | 1 | Core is halted |
| core_running | input | 1 | Core is running |
| core_have_reset | input | 1 | Core has been reset |

## Verification
Some events are hard to produce because they must coincide with a held resume request. These are a control write arriving in the same cycle as the acknowledge, a deactivating write arriving in the same cycle as the acknowledge, and a resume write that also sets the halt bit. The stimulus makes these meetings frequent. It drives a random acknowledge on a quarter of the cycles, it often picks the control address, and it sets bit 0 on most writes, so the unit spends long stretches in `RC_RESUME` while writes keep arriving. Directed steps first hold the resume request for several cycles without an acknowledge, and they check the combined halt-and-resume write and writes made while inactive.

// File: rtl/dbg_runctl_pkg.sv
package dbg_runctl_pkg;

    typedef enum logic [1:0] {
        RC_OFF    = 2'd0,
        RC_ON     = 2'd1,
        RC_RESUME = 2'd2
    } rc_state_e;

    localparam int CTL_HALT_BIT   = 31;
    localparam int CTL_RESUME_BIT = 30;
    localparam int CTL_RESET_BIT  = 1;
    localparam int CTL_ACTIVE_BIT = 0;

    localparam int ST_HAVERESET_HI = 19;
    localparam int ST_HAVERESET_LO = 18;
    localparam int ST_RUN_ALL      = 11;
    localparam int ST_RUN_ANY      = 10;
    localparam int ST_HALT_ALL     = 9;
    localparam int ST_HALT_ANY     = 8;
    localparam int ST_VERSION_W    = 4;

endpackage

// File: rtl/dbg_runctl_decode.sv
module dbg_runctl_decode #(
    parameter int ADDR_W = 8,
    parameter int NREG   = 3,
    parameter logic [NREG*ADDR_W-1:0] ADDR_LIST = {8'h12, 8'h11, 8'h10}
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NREG-1:0]   sel,
    output logic              hit
);

    for (genvar i = 0; i < NREG; i++) begin : g_match
        assign sel[i] = (addr == ADDR_LIST[i*ADDR_W +: ADDR_W]);
    end

    assign hit = |sel;

endmodule

// File: rtl/dbg_runctl_status.sv
module dbg_runctl_status
    import dbg_runctl_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int VERSION = 2
) (
    input  logic              halted,
    input  logic              running,
    input  logic              have_reset,
    output logic [DATA_W-1:0] word
);

    localparam logic [ST_VERSION_W-1:0] VER_FIELD = ST_VERSION_W'(VERSION);

    always_comb begin
        word = '0;
        word[ST_VERSION_W-1:0] = VER_FIELD;
        // single hart: the "all" and "any" forms coincide
        word[ST_HALT_ANY]      = halted;
        word[ST_HALT_ALL]      = halted;
        word[ST_RUN_ANY]       = running;
        word[ST_RUN_ALL]       = running;
        word[ST_HAVERESET_LO]  = have_reset;
        word[ST_HAVERESET_HI]  = have_reset;
    end

endmodule

// File: rtl/dbg_runctl_ctrl.sv
module dbg_runctl_ctrl
    import dbg_runctl_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              resume_ack,
    output logic              halt_req,
    output logic              resume_req,
    output logic              ndm_reset,
    output logic              active,
    output logic [DATA_W-1:0] ctrl_rdata
);

    rc_state_e state_q, state_d;
    logic      halt_q, reset_q;

    logic w_active, w_halt, w_resume, w_reset;
    assign w_active = wdata[CTL_ACTIVE_BIT];
    assign w_halt   = wdata[CTL_HALT_BIT];
    assign w_resume = wdata[CTL_RESUME_BIT];
    assign w_reset  = wdata[CTL_RESET_BIT];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RC_OFF;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RC_OFF: begin
                if (wr_en && w_active) state_d = RC_ON;               // ACTIVATE
            end
            RC_ON: begin
                if (wr_en && !w_active)                    state_d = RC_OFF;    // DEACTIVATE
                else if (wr_en && w_resume && !w_halt)     state_d = RC_RESUME; // START_RESUME
            end
            RC_RESUME: begin
                if (wr_en && !w_active) state_d = RC_OFF;  // DEACTIVATE
                else if (resume_ack)    state_d = RC_ON;   // ACK
            end
            default: state_d = RC_OFF;
        endcase
    end

    // level request registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_q  <= 1'b0;
            reset_q <= 1'b0;
        end else if (wr_en && state_q != RC_OFF) begin
            halt_q  <= w_active & w_halt;
            reset_q <= w_active & w_reset;
        end
    end

    // outputs
    always_comb begin
        active     = (state_q != RC_OFF);
        resume_req = (state_q == RC_RESUME);
        halt_req   = halt_q;
        ndm_reset  = reset_q;
        ctrl_rdata = '0;
        ctrl_rdata[CTL_HALT_BIT]   = halt_q;
        ctrl_rdata[CTL_RESET_BIT]  = reset_q;
        ctrl_rdata[CTL_ACTIVE_BIT] = active;
    end

    AST_RESUME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_req && !resume_ack && !(wr_en && !w_active)) |=> resume_req); // R7
    AST_RESUME_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_req && resume_ack) |=> !resume_req); // R7
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !(halt_req || resume_req || ndm_reset)); // R4
    AST_OFF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && wr_en) |=> (!halt_req && !ndm_reset && !resume_req)); // R4
    AST_HALT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (active && wr_en && w_active) |=> (halt_req == $past(w_halt))); // R5
    AST_DEACT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !w_active) |=> !(halt_req || resume_req || ndm_reset)); // R6

endmodule

// File: rtl/dbg_runctl.sv
module dbg_runctl
    import dbg_runctl_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'('h10),
    parameter logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'('h11),
    parameter logic [ADDR_W-1:0] INFO_ADDR = ADDR_W'('h12),
    parameter int VERSION = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              core_halt_req,
    output logic              core_resume_req,
    output logic              core_ndm_reset,
    input  logic              core_resume_ack,
    input  logic              core_halted,
    input  logic              core_running,
    input  logic              core_have_reset
);

    localparam int NREG    = 3;
    localparam int SEL_CTL = 0;
    localparam int SEL_ST  = 1;
    localparam int SEL_INF = 2;

    logic [NREG-1:0]   sel;
    logic              hit;
    logic              ctl_wr;
    logic              unit_active;
    logic [DATA_W-1:0] ctl_word, stat_word, rd_mux;
    logic              rsp_valid_q, rsp_ok_q;
    logic [DATA_W-1:0] rsp_rdata_q;

    dbg_runctl_decode #(
        .ADDR_W    (ADDR_W),
        .NREG      (NREG),
        .ADDR_LIST ({INFO_ADDR, STAT_ADDR, CTRL_ADDR})
    ) u_decode (
        .addr (req_addr),
        .sel  (sel),
        .hit  (hit)
    );

    assign ctl_wr = req_valid && req_write && sel[SEL_CTL];

    dbg_runctl_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (ctl_wr),
        .wdata      (req_wdata),
        .resume_ack (core_resume_ack),
        .halt_req   (core_halt_req),
        .resume_req (core_resume_req),
        .ndm_reset  (core_ndm_reset),
        .active     (unit_active),
        .ctrl_rdata (ctl_word)
    );

    dbg_runctl_status #(.DATA_W(DATA_W), .VERSION(VERSION)) u_status (
        .halted     (core_halted),
        .running    (core_running),
        .have_reset (core_have_reset),
        .word       (stat_word)
    );

    always_comb begin
        rd_mux = '0;
        if (!req_write) begin
            unique case (1'b1)
                sel[SEL_CTL]: rd_mux = ctl_word;
                sel[SEL_ST]:  rd_mux = stat_word;
                sel[SEL_INF]: rd_mux = '0;
                default:      rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_ok_q    <= 1'b0;
            rsp_rdata_q <= '0;
        end else begin
            rsp_valid_q <= req_valid;
            rsp_ok_q    <= req_valid && hit;
            rsp_rdata_q <= req_valid ? rd_mux : '0;
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_ok    = rsp_ok_q;
    assign rsp_rdata = rsp_rdata_q;

    AST_RSP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2
    AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R2
    AST_BAD_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !hit) |=> (!rsp_ok && rsp_rdata == '0)); // R3
    AST_VERSION: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && sel[SEL_ST]) |=>
            (rsp_rdata[ST_VERSION_W-1:0] == ST_VERSION_W'(VERSION))); // R9
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel)); // R3
    AST_ACTIVE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && sel[SEL_CTL]) |=>
            (rsp_rdata[CTL_ACTIVE_BIT] == $past(unit_active))); // R8

endmodule

// File: tb/sim_dbg_runctl.sv
module sim_dbg_runctl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_ok;
    logic [31:0] rsp_rdata;
    logic        core_halt_req, core_resume_req, core_ndm_reset;
    logic        core_resume_ack = 1'b0;
    logic        core_halted = 1'b0;
    logic        core_running = 1'b0;
    logic        core_have_reset = 1'b0;

    int checks = 0;
    int errors = 0;

    // expected state
    bit m_active = 0, m_halt = 0, m_ndm = 0, m_resume = 0;

    always #4 clk = ~clk;   // 125 MHz

    dbg_runctl u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_rdata(rsp_rdata),
        .core_halt_req(core_halt_req), .core_resume_req(core_resume_req),
        .core_ndm_reset(core_ndm_reset), .core_resume_ack(core_resume_ack),
        .core_halted(core_halted), .core_running(core_running),
        .core_have_reset(core_have_reset)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic bit owned(input logic [7:0] a);
        return (a == 8'h10) || (a == 8'h11) || (a == 8'h12);
    endfunction

    function automatic logic [31:0] ctl_word();
        return {m_halt, 29'b0, m_ndm, m_active};
    endfunction

    function automatic logic [31:0] stat_word(input bit h, input bit r, input bit hr);
        return {12'b0, hr, hr, 6'b0, r, r, h, h, 4'b0, 4'd2};
    endfunction

    // one request cycle: drive at negedge, check just after the next posedge
    task automatic step(input string tag, input bit v, input bit w,
                        input logic [7:0] a, input logic [31:0] d,
                        input bit ack, input bit h, input bit r, input bit hr);
        bit          e_ok;
        logic [31:0] e_rd;
        @(negedge clk);
        req_valid = v; req_write = w; req_addr = a; req_wdata = d;
        core_resume_ack = ack; core_halted = h; core_running = r; core_have_reset = hr;
        e_ok = v && owned(a);
        e_rd = 32'h0;
        if (v && !w && a == 8'h10) e_rd = ctl_word();
        if (v && !w && a == 8'h11) e_rd = stat_word(h, r, hr);
        // next expected state
        if (v && w && a == 8'h10) begin
            if (!m_active) begin
                m_active = d[0];
            end else if (!d[0]) begin
                m_active = 0; m_halt = 0; m_ndm = 0; m_resume = 0;
            end else begin
                m_halt = d[31]; m_ndm = d[1];
                if (m_resume) begin
                    if (ack) m_resume = 0;
                end else if (d[30] && !d[31]) begin
                    m_resume = 1;
                end
            end
        end else if (m_resume && ack) begin
            m_resume = 0;
        end
        @(posedge clk);
        #2;
        chk("R2", "rsp_valid", {31'b0, rsp_valid}, {31'b0, v});
        if (v) begin
            chk(tag, "rsp_ok", {31'b0, rsp_ok}, {31'b0, e_ok});
            chk(tag, "rsp_rdata", rsp_rdata, e_rd);
        end
        chk(m_active ? "R5" : "R4", "halt_req", {31'b0, core_halt_req}, {31'b0, m_halt});
        chk(m_active ? "R5" : "R4", "ndm_reset", {31'b0, core_ndm_reset}, {31'b0, m_ndm});
        chk(m_active ? "R7" : "R4", "resume_req", {31'b0, core_resume_req}, {31'b0, m_resume});
    endtask

    task automatic idle(input int n, input bit ack);
        for (int i = 0; i < n; i++) step("R7", 0, 0, 8'h00, 32'h0, ack, 0, 0, 0);
    endtask

    initial begin
        #(8 * 200000);
        checks++; errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", "rsp_valid", {31'b0, rsp_valid}, 32'h0);
        chk("R1", "requests", {29'b0, core_halt_req, core_resume_req, core_ndm_reset}, 32'h0);
        step("R1", 1, 0, 8'h10, 32'h0, 0, 0, 0, 0);

        // R4 inactive writes touch only bit 0
        step("R4", 1, 1, 8'h10, 32'hC000_0002, 0, 0, 0, 0);
        step("R8", 1, 0, 8'h10, 32'h0, 0, 0, 0, 0);
        step("R4", 1, 1, 8'h10, 32'hC000_0003, 0, 0, 0, 0);
        step("R8", 1, 0, 8'h10, 32'h0, 0, 0, 0, 0);

        // R5 halt and reset levels
        step("R5", 1, 1, 8'h10, 32'h8000_0003, 0, 0, 0, 0);
        step("R8", 1, 0, 8'h10, 32'h0, 0, 0, 0, 0);
        step("R5", 1, 1, 8'h10, 32'h0000_0001, 0, 0, 0, 0);

        // R7 resume held until ack
        step("R7", 1, 1, 8'h10, 32'h4000_0001, 0, 0, 0, 0);
        step("R8", 1, 0, 8'h10, 32'h0, 0, 0, 0, 0);   // bit 30 reads 0
        idle(3, 0);
        idle(1, 1);
        idle(1, 0);
        // R7 resume ignored with halt set
        step("R7", 1, 1, 8'h10, 32'hC000_0001, 0, 0, 0, 0);
        // R6 deactivate clears everything, even with ack
        step("R7", 1, 1, 8'h10, 32'h4000_0003, 0, 0, 0, 0);
        step("R6", 1, 1, 8'h10, 32'h0000_0000, 1, 0, 0, 0);
        step("R6", 1, 0, 8'h10, 32'h0, 0, 0, 0, 0);

        // R3 unowned addresses
        step("R3", 1, 0, 8'h13, 32'h0, 0, 1, 1, 1);
        step("R3", 1, 1, 8'h04, 32'hFFFF_FFFF, 0, 0, 0, 0);
        step("R3", 1, 1, 8'h90, 32'h0000_0001, 0, 0, 0, 0);
        step("R3", 1, 0, 8'h10, 32'h0, 0, 0, 0, 0);

        // R9 status patterns
        for (int p = 0; p < 8; p++)
            step("R9", 1, 0, 8'h11, 32'h0, 0, p[0], p[1], p[2]);
        // R10 hart info and read-only writes
        step("R10", 1, 0, 8'h12, 32'h0, 0, 1, 1, 1);
        step("R10", 1, 1, 8'h11, 32'hFFFF_FFFF, 0, 0, 0, 0);
        step("R10", 1, 1, 8'h12, 32'hFFFF_FFFF, 0, 0, 0, 0);
        step("R10", 1, 0, 8'h10, 32'h0, 0, 0, 0, 0);

        // random mix
        for (int n = 0; n < 3000; n++) begin
            int unsigned sel = $urandom % 8;
            logic [7:0]  a;
            logic [31:0] d;
            string       tg;
            bit          v, w;
            v = ($urandom % 6) != 0;
            w = ($urandom % 2) != 0;
            d = $urandom;
            d[0] = ($urandom % 5) != 0;
            case (sel)
                0, 1, 2, 5: a = 8'h10;
                3:          a = 8'h11;
                4:          a = 8'h12;
                default:    a = 8'($urandom);
            endcase
            if (!owned(a))          tg = "R3";
            else if (a == 8'h11)    tg = "R9";
            else if (a == 8'h12)    tg = "R10";
            else if (w)             tg = "R5";
            else                    tg = "R8";
            step(tg, v, w, a, d, ($urandom % 4) == 0,
                 $urandom % 2 != 0, $urandom % 2 != 0, $urandom % 2 != 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule